// File: doc/BRIEF.md
# System Clock Source Switch with Slewed Post-Divider

This block picks the system clock from up to eight input sources and divides it by a programmable post-divider. All sources share one control clock. Each source appears as a one-cycle tick on that clock, and the output is a one-cycle tick as well. Software asks for a new source by writing a 3-bit request and setting a start bit in the source-control register. The block checks the ready input of the requested source. If the source is not ready, the request is refused and the active source keeps running. An accepted request goes through a per-source two-stage gate handshake: the old source is gated off completely before the new one is let through.

The slew register holds the post-divider target and a step-hold exponent, plus separate enables for slewing toward a larger ratio (slower output) and toward a smaller ratio (faster output). When slewing is enabled for the needed direction, the effective ratio moves one step at a time and holds each step for a fixed number of output ticks. A busy flag reads high until the effective ratio equals the target.

Top module: `clk_switch_slew`

## Requirements
- R1: After reset the source-control register reads 0, which means source 0 is active, no request is pending and the start bit is clear. The slew register also reads 0, so the output ticks on every tick of source 0.
- R2: The source-control register has the start bit at bit 0, the request at [10:8] and the active-source status at [14:12]. A write with bit 0 set loads the request and reads back bit 0 as 1. The ready input of the requested source is sampled one cycle later. If it is set, the status field takes the request value and bit 0 clears in the same clock edge. The old source's gate is closed before the new source's gate opens.
- R3: If the requested source is not ready, the request is refused. Bit 0 clears and the status field keeps its old value.
- R4: Writes to the source-control register are ignored while bit 0 reads 1.
- R5: The output emits one tick for every (post-divider + 1) ticks of the active source.
- R6: The slew register has the post-divider at [23:20]. When slewing is disabled for the direction of a change, the busy flag (bit 0) reads 1 in the cycle after the write and reads 0 one cycle later, at the new ratio.
- R7: With the down-slew enable (bit 1) set and a larger target, the effective ratio rises by one per step. Each step is held for 2^S output ticks, where S is the field at [10:8]. Busy therefore stays high for exactly (steps × 2^S) output ticks.
- R8: With the up-slew enable (bit 2) set and a smaller target, the effective ratio falls by one per step, with the same hold and busy behaviour as in R7.
- R9: Bits 1, 2, [10:8] and [23:20] of the slew register read back as written. Writing bit 0 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | N_SRC | One-cycle tick per source period |
| src_ready_i | input | N_SRC | Source present and stable |
| osc_wr_i | input | 1 | Source-control register write strobe |
| osc_wdata_i | input | 32 | Source-control write data |
| osc_rdata_o | output | 32 | Source-control read data |
| slew_wr_i | input | 1 | Slew register write strobe |
| slew_wdata_i | input | 32 | Slew register write data |
| slew_rdata_o | output | 32 | Slew register read data |
| sys_tick_o | output | 1 | Divided system tick |

## Verification
A wrong gate or handshake state shows up as a start bit that never clears, or as a status field that changes when a request should have been refused. A wrong handshake state can also produce output ticks whose spacing matches the wrong source period; this becomes visible within a few source periods after the switch ends. A bad effective-divider or hold-counter value changes the spacing between output ticks, or changes how many output ticks occur while busy is high. That shows up within the next 2^S output ticks. Both effects are measured at the ports against spacings computed from each source's tick period and the programmed ratio.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int SEL_W  = 3;
  localparam int SEL_N  = 1 << SEL_W;
  localparam int PDIV_W = 4;
  localparam int SDIV_W = 3;
  localparam int HOLD_W = (1 << SDIV_W) - 1;

  // field positions decoded by software
  localparam int OSC_GO_B   = 0;
  localparam int OSC_REQ_LO = 8;
  localparam int OSC_CUR_LO = 12;
  localparam int SLW_BSY_B  = 0;
  localparam int SLW_DN_B   = 1;
  localparam int SLW_UP_B   = 2;
  localparam int SLW_SD_LO  = 8;
  localparam int SLW_PD_LO  = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_DROP, ST_RAISE} sw_st_e;
endpackage

// File: rtl/clk_sw_ctrl.sv
module clk_sw_ctrl
  import clk_sw_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [N_SRC-1:0] src_ready_i,
  input  logic             wr_i,
  input  logic             go_i,
  input  logic [SEL_W-1:0] req_sel_i,
  output logic [SEL_W-1:0] cur_o,
  output logic [SEL_W-1:0] req_o,
  output logic             swen_o,
  output logic             mux_tick_o
);
  sw_st_e           st_q;
  logic [SEL_W-1:0] cur_q, nsel_q;
  logic             swen_q;
  logic [SEL_N-1:0] req_q, stg1, gate, tick_ext, rdy_ext;

  assign tick_ext = SEL_N'(src_tick_i);
  assign rdy_ext  = SEL_N'(src_ready_i);

  // two-flop gate per source, advanced by that source's own ticks
  for (genvar i = 0; i < SEL_N; i++) begin : g_gate
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= (i == 0);
        s2_q <= (i == 0);
      end else if (tick_ext[i]) begin
        s1_q <= req_q[i];
        s2_q <= s1_q;
      end
    end
    assign stg1[i] = s1_q;
    assign gate[i] = s2_q;
  end

  assign mux_tick_o = |(tick_ext & gate);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      nsel_q <= '0;
      swen_q <= 1'b0;
      req_q  <= SEL_N'(1);
    end else begin
      unique case (st_q)
        ST_IDLE: if (wr_i) begin
          nsel_q <= req_sel_i;
          if (go_i) begin
            swen_q <= 1'b1;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: if (!rdy_ext[nsel_q] || nsel_q == cur_q) begin
          swen_q <= 1'b0;
          st_q   <= ST_IDLE;
        end else begin
          req_q[cur_q] <= 1'b0;
          st_q         <= ST_DROP;
        end
        ST_DROP: if (!stg1[cur_q] && !gate[cur_q]) begin
          req_q[nsel_q] <= 1'b1;
          st_q          <= ST_RAISE;
        end
        ST_RAISE: if (gate[nsel_q]) begin
          cur_q  <= nsel_q;
          swen_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_o  = cur_q;
  assign req_o  = nsel_q;
  assign swen_o = swen_q;

  // R2
  gate_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gate));
  // R2
  cur_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> (!swen_q && $past(swen_q)));
  // R3
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHECK && !rdy_ext[nsel_q]) |=> (!swen_q && $stable(cur_q)));
  // R4
  busy_wr_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swen_q && st_q != ST_IDLE) |=> $stable(nsel_q));
endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import clk_sw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_tick_i,
  input  logic [PDIV_W-1:0] tgt_i,
  input  logic              dn_en_i,
  input  logic              up_en_i,
  input  logic [SDIV_W-1:0] sdiv_i,
  output logic              busy_o,
  output logic              tick_o
);
  logic [PDIV_W-1:0] eff_q, cnt_q;
  logic [HOLD_W-1:0] hold_q, hold_lim;
  logic              tick_q, busy, go_up, slew_on, step;

  assign busy     = eff_q != tgt_i;
  assign go_up    = eff_q < tgt_i;
  assign slew_on  = go_up ? dn_en_i : up_en_i;
  assign hold_lim = (HOLD_W'(1) << sdiv_i) - HOLD_W'(1);
  assign step     = tick_q && hold_q == hold_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (mux_tick_i) begin
      tick_q <= cnt_q >= eff_q;
      cnt_q  <= (cnt_q >= eff_q) ? '0 : cnt_q + PDIV_W'(1);
    end else begin
      tick_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= '0;
      hold_q <= '0;
    end else if (!busy) begin
      hold_q <= '0;
    end else if (!slew_on) begin
      eff_q  <= tgt_i;
      hold_q <= '0;
    end else if (step) begin
      eff_q  <= go_up ? eff_q + PDIV_W'(1) : eff_q - PDIV_W'(1);
      hold_q <= '0;
    end else if (tick_q) begin
      hold_q <= hold_q + HOLD_W'(1);
    end
  end

  assign busy_o = busy;
  assign tick_o = tick_q;

  // R5
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(mux_tick_i));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(eff_q));
  // R7
  dn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_up && dn_en_i) |=> (eff_q == $past(eff_q) || eff_q == $past(eff_q) + PDIV_W'(1)));
  // R8
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !go_up && up_en_i) |=> (eff_q == $past(eff_q) || eff_q == $past(eff_q) - PDIV_W'(1)));
endmodule

// File: rtl/clk_switch_slew.sv
module clk_switch_slew
  import clk_sw_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [N_SRC-1:0] src_ready_i,
  input  logic             osc_wr_i,
  input  logic [31:0]      osc_wdata_i,
  output logic [31:0]      osc_rdata_o,
  input  logic             slew_wr_i,
  input  logic [31:0]      slew_wdata_i,
  output logic [31:0]      slew_rdata_o,
  output logic             sys_tick_o
);
  logic [SEL_W-1:0]  cur, req;
  logic              swen, mux_tick, busy;
  logic              dn_q, up_q;
  logic [SDIV_W-1:0] sd_q;
  logic [PDIV_W-1:0] pd_q;
  logic              unused_wbits;

  assign unused_wbits = ^{osc_wdata_i[31:11], osc_wdata_i[7:1],
                          slew_wdata_i[31:24], slew_wdata_i[19:11],
                          slew_wdata_i[7:3], slew_wdata_i[SLW_BSY_B]};

  clk_sw_ctrl #(.N_SRC(N_SRC)) u_ctrl (
    .clk_i, .rst_ni,
    .src_tick_i, .src_ready_i,
    .wr_i      (osc_wr_i),
    .go_i      (osc_wdata_i[OSC_GO_B]),
    .req_sel_i (osc_wdata_i[OSC_REQ_LO +: SEL_W]),
    .cur_o     (cur),
    .req_o     (req),
    .swen_o    (swen),
    .mux_tick_o(mux_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_q <= 1'b0;
      up_q <= 1'b0;
      sd_q <= '0;
      pd_q <= '0;
    end else if (slew_wr_i) begin
      dn_q <= slew_wdata_i[SLW_DN_B];
      up_q <= slew_wdata_i[SLW_UP_B];
      sd_q <= slew_wdata_i[SLW_SD_LO +: SDIV_W];
      pd_q <= slew_wdata_i[SLW_PD_LO +: PDIV_W];
    end
  end

  clk_postdiv u_div (
    .clk_i, .rst_ni,
    .mux_tick_i(mux_tick),
    .tgt_i     (pd_q),
    .dn_en_i   (dn_q),
    .up_en_i   (up_q),
    .sdiv_i    (sd_q),
    .busy_o    (busy),
    .tick_o    (sys_tick_o)
  );

  always_comb begin
    osc_rdata_o = '0;
    osc_rdata_o[OSC_GO_B]             = swen;
    osc_rdata_o[OSC_REQ_LO +: SEL_W]  = req;
    osc_rdata_o[OSC_CUR_LO +: SEL_W]  = cur;
    slew_rdata_o = '0;
    slew_rdata_o[SLW_BSY_B]           = busy;
    slew_rdata_o[SLW_DN_B]            = dn_q;
    slew_rdata_o[SLW_UP_B]            = up_q;
    slew_rdata_o[SLW_SD_LO +: SDIV_W] = sd_q;
    slew_rdata_o[SLW_PD_LO +: PDIV_W] = pd_q;
  end
endmodule

// File: tb/clk_switch_slew_tb.sv
`timescale 1ns/1ps
module clk_switch_slew_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  tick, rdy;
  logic        osc_wr = 1'b0, slew_wr = 1'b0;
  logic [31:0] osc_wd = '0, slew_wd = '0, osc_rd, slew_rd;
  logic        sys_tick;
  int          cyc = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk_i = ~clk_i;
  always @(negedge clk_i) cyc <= cyc + 1;
  always_comb for (int i = 0; i < 8; i++) tick[i] = ((cyc % (i + 3)) == 0);

  clk_switch_slew u_dut (
    .clk_i, .rst_ni, .src_tick_i(tick), .src_ready_i(rdy),
    .osc_wr_i(osc_wr), .osc_wdata_i(osc_wd), .osc_rdata_o(osc_rd),
    .slew_wr_i(slew_wr), .slew_wdata_i(slew_wd), .slew_rdata_o(slew_rd),
    .sys_tick_o(sys_tick)
  );

  function automatic int period(int s); return s + 3; endfunction
  function automatic logic [31:0] osc_word(int s, bit go);
    return (32'(s) << 8) | 32'(go);
  endfunction
  function automatic logic [31:0] slew_word(int pd, int sd, bit up, bit dn);
    return (32'(pd) << 20) | (32'(sd) << 8) | (32'(up) << 2) | (32'(dn) << 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_osc(logic [31:0] d);
    osc_wd = d; osc_wr = 1'b1;
    @(negedge clk_i); osc_wr = 1'b0;
  endtask

  task automatic wr_slew(logic [31:0] d);
    slew_wd = d; slew_wr = 1'b1;
    @(negedge clk_i); slew_wr = 1'b0;
  endtask

  task automatic wait_swen(output bit ok);
    ok = 0;
    for (int k = 0; k < 400; k++) begin
      if (!osc_rd[0]) begin ok = 1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic meas(output int d);
    int n; longint t0;
    n = 0; t0 = 0; d = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk_i);
      if (sys_tick) begin
        n++;
        if (n == 3) t0 = $time;
        if (n == 4) begin d = int'(($time - t0) / 8); break; end
      end
    end
  endtask

  task automatic ticks_while_busy(output int c);
    c = 0;
    for (int k = 0; k < 20000; k++) begin
      if (!slew_rd[0]) break;
      if (sys_tick) c++;
      @(negedge clk_i);
    end
  endtask

  task automatic do_switch(int s, int cur_exp, string tag);
    bit ok; int d;
    wr_osc(osc_word(s, 1));
    chk(osc_rd[0] == 1'b1, {tag, " start bit set"}, int'(osc_rd[0]), 1);
    wait_swen(ok);
    chk(ok, {tag, " start bit clears"}, int'(ok), 1);
    chk(int'(osc_rd[14:12]) == cur_exp, {tag, " active source"}, int'(osc_rd[14:12]), cur_exp);
    meas(d);
    chk(d == period(cur_exp) * (int'(slew_rd[23:20]) + 1), {tag, " tick spacing"},
        d, period(cur_exp) * (int'(slew_rd[23:20]) + 1));
  endtask

  initial begin
    int d, c, cur, s, pd;
    bit r;
    void'($urandom(32'd1234));
    rdy = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(osc_rd == 32'h0, "R1 osc reg reset", int'(osc_rd), 0);
    chk(slew_rd == 32'h0, "R1 slew reg reset", int'(slew_rd), 0);
    meas(d);
    chk(d == 3, "R1 R5 reset spacing", d, 3);
    // R2 accepted switch
    do_switch(5, 5, "R2");
    cur = 5;
    // R3 refused switch
    rdy[2] = 1'b0;
    do_switch(2, 5, "R3");
    rdy[2] = 1'b1;
    // R4 write during switch ignored
    wr_osc(osc_word(1, 1));
    wr_osc(osc_word(7, 1));
    wait_swen(r);
    chk(int'(osc_rd[14:12]) == 1, "R4 active after ignored write", int'(osc_rd[14:12]), 1);
    chk(int'(osc_rd[10:8]) == 1, "R4 request field unchanged", int'(osc_rd[10:8]), 1);
    cur = 1;
    // R6 jump without slew
    wr_slew(slew_word(2, 0, 0, 0));
    chk(slew_rd[0] == 1'b1, "R6 busy one cycle", int'(slew_rd[0]), 1);
    @(negedge clk_i);
    chk(slew_rd[0] == 1'b0, "R6 busy cleared", int'(slew_rd[0]), 0);
    meas(d);
    chk(d == 12, "R5 R6 spacing ratio 3", d, 12);
    // R9 readback, bit 0 write ignored
    wr_slew(slew_word(2, 1, 0, 1) | 32'h1);
    chk(slew_rd == slew_word(2, 1, 0, 1), "R9 slew readback", int'(slew_rd),
        int'(slew_word(2, 1, 0, 1)));
    // R7 down slew 2 -> 5, hold 2
    wr_slew(slew_word(5, 1, 0, 1));
    ticks_while_busy(c);
    chk(c == 3 * 2, "R7 ticks while busy", c, 6);
    meas(d);
    chk(d == 4 * 6, "R7 final spacing", d, 24);
    // R8 up slew 5 -> 1, hold 1
    wr_slew(slew_word(1, 0, 1, 0));
    ticks_while_busy(c);
    chk(c == 4, "R8 ticks while busy", c, 4);
    meas(d);
    chk(d == 4 * 2, "R8 final spacing", d, 8);
    // random mix
    for (int it = 0; it < 20; it++) begin
      s  = int'($urandom % 8);
      r  = ($urandom % 4) != 0;
      pd = int'($urandom % 4);
      rdy = 8'hFF;
      rdy[s] = r;
      wr_slew(slew_word(pd, 0, 0, 0));
      if (r) cur = s;
      do_switch(s, cur, r ? "R2 R5 random" : "R3 R5 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule